// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges up to four rectangular layers into one stream of RGB pixels. For every screen coordinate presented on its input, each enabled layer that covers that coordinate offers one ARGB pixel. Composition happens in two stages. First, every layer is steered into one of two pipes. Inside a pipe the covering layer with the highest priority supplies the pixel outright, with no mixing between layers. Second, the pipe 0 result is alpha-blended over a programmable background colour, and the pipe 1 result is then alpha-blended over that.

Each layer carries an 8-bit global alpha with its own enable. When the enable is set, the global alpha scales the per-pixel alpha. An optional defect-compatibility mode drops a translucent pixel that comes from the lowest slot (pipe 0, priority 0) and shows the background in its place, so that software written for hardware with that flaw sees the same picture. Pixel fetch and format conversion happen upstream. Every ARGB word arrives with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. Formats without alpha are presented with alpha 255.

Top module: `layer_compositor`

## Requirements
- R1: A pixel presented with `px_valid` high appears on `out_rgb` with `out_valid` high exactly two clock edges later. `out_valid` is low in every cycle whose input two edges earlier was not valid.
- R2: Layer i covers a coordinate when its enable bit is set and lx ≤ x < lx+w and ly ≤ y < ly+h. A disabled or non-covering layer contributes nothing. With no covering layer the output equals `bg_rgb`.
- R3: A coordinate with x ≥ `disp_w` or y ≥ `disp_h` produces `bg_rgb` whatever the layers hold.
- R4: Within one pipe, the covering layer with the numerically greatest 2-bit priority supplies the pipe pixel unblended. On equal priority the lower layer index wins.
- R5: Effective alpha equals the pixel alpha when the global-alpha enable is clear. When the enable is set it equals (pixel_alpha·global_alpha + 127) / 255, truncated.
- R6: Each channel blends as (a·top + (255−a)·bottom + 127) / 255, truncated. Pipe 0 blends over the background first, then pipe 1 blends over that result, each stage using its own pipe's effective alpha.
- R7: A pipe with no covering layer is fully transparent (alpha 0), so the stage beneath shows through unchanged.
- R8: With `quirk_en` high, a pipe 0 winner at priority 0 whose effective alpha is below 255 is replaced by transparency, so the background appears in that place. A fully opaque such pixel, a winner at another priority, or `quirk_en` low blends normally.
- R9: After reset, `out_valid` is 0 and `out_rgb` is 0.
- R10: `out_rgb` keeps its value in every cycle in which `out_valid` is low, even when layer settings change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| px_valid | input | 1 | Coordinate on px_x/px_y is to be composited |
| px_x | input | CW | Screen column |
| px_y | input | CW | Screen row |
| disp_w | input | CW | Active display width |
| disp_h | input | CW | Active display height |
| bg_rgb | input | 24 | Background colour |
| quirk_en | input | 1 | Lowest-slot defect compatibility |
| lay_en | input | NL | Per-layer enable |
| lay_x | input | NL*CW | Per-layer left edge |
| lay_y | input | NL*CW | Per-layer top edge |
| lay_w | input | NL*CW | Per-layer width |
| lay_h | input | NL*CW | Per-layer height |
| lay_pipe | input | NL | Per-layer pipe select (0 or 1) |
| lay_prio | input | NL*2 | Per-layer priority |
| lay_galpha | input | NL*8 | Per-layer global alpha |
| lay_galpha_en | input | NL | Per-layer global alpha enable |
| lay_argb | input | NL*32 | Per-layer pixel at the current coordinate |
| out_valid | output | 1 | Composited pixel valid |
| out_rgb | output | 24 | Composited pixel |

## Verification
The assertions watch, on every cycle, the two-edge valid latency, the hold of the output between valid pixels, and the cases in which the result must be the background: all layers disabled, or a coordinate off the display. The arithmetic can only be shown by the bench's scenarios, because it depends on a chosen layer configuration. These scenarios cover priority contention inside a pipe, tie breaking, global alpha scaling, rounding of both blend stages, the edges of a layer rectangle, and each branch of the lowest-slot defect mode.

// File: rtl/compositor_pkg.sv
// Shared types and arithmetic helpers for the two-pipe compositor.
// Assumes 8-bit channels and alpha; all divisions are by the constant 255.
package compositor_pkg;

    typedef struct packed {
        logic [7:0]  a;
        logic [23:0] rgb;
    } argb_t;

    // Rounded product of two 8-bit fractions of 255.
    function automatic logic [7:0] scale_alpha(input logic [7:0] pa, input logic [7:0] ga);
        logic [15:0] s;
        s = {8'd0, pa} * {8'd0, ga} + 16'd127;
        return 8'(s / 16'd255);
    endfunction

    // One channel of top-over-bottom blending with rounding.
    function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] top,
                                        input logic [7:0] bot);
        logic [15:0] s;
        s = {8'd0, a} * {8'd0, top} + {8'd0, 8'd255 - a} * {8'd0, bot} + 16'd127;
        return 8'(s / 16'd255);
    endfunction

endpackage

// File: rtl/layer_cover.sv
// Decides whether one layer covers the current coordinate and forms its
// effective alpha. Assumes the rectangle edge sums fit in CW+1 bits.
module layer_cover
    import compositor_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          en,
    input  logic [CW-1:0] px_x,
    input  logic [CW-1:0] px_y,
    input  logic [CW-1:0] lx,
    input  logic [CW-1:0] ly,
    input  logic [CW-1:0] lw,
    input  logic [CW-1:0] lh,
    input  logic [31:0]   argb_in,
    input  logic [7:0]    galpha,
    input  logic          galpha_en,
    output logic          hit,
    output argb_t         eff
);
    logic [CW:0] x_end, y_end;

    // Rectangle membership test, right and bottom edges exclusive.
    always_comb begin
        x_end = {1'b0, lx} + {1'b0, lw};
        y_end = {1'b0, ly} + {1'b0, lh};
        hit   = en && (px_x >= lx) && ({1'b0, px_x} < x_end)
                   && (px_y >= ly) && ({1'b0, px_y} < y_end);
    end

    // Effective alpha: global alpha scales pixel alpha when enabled.
    always_comb begin
        eff.rgb = argb_in[23:0];
        eff.a   = galpha_en ? scale_alpha(argb_in[31:24], galpha) : argb_in[31:24];
    end
endmodule

// File: rtl/pipe_select.sv
// Picks, for one pipe, the covering layer with the greatest priority.
// Ties go to the lower layer index. No blending between layers.
module pipe_select #(
    parameter int NL      = 4,
    parameter int PW      = 2,
    parameter bit PIPE_ID = 1'b0
) (
    input  logic [NL-1:0]    hit,
    input  logic [NL-1:0]    pipe_sel,
    input  logic [NL*PW-1:0] prio,
    input  logic [NL*32-1:0] px,
    output logic             found,
    output logic [31:0]      pix,
    output logic [PW-1:0]    win_prio
);
    // Priority scan; strict greater-than keeps the earliest on ties.
    always_comb begin
        found    = 1'b0;
        pix      = '0;
        win_prio = '0;
        for (int i = 0; i < NL; i++) begin
            if (hit[i] && (pipe_sel[i] == PIPE_ID) &&
                (!found || (prio[i*PW +: PW] > win_prio))) begin
                found    = 1'b1;
                pix      = px[i*32 +: 32];
                win_prio = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/rgb_blend.sv
// Blends a 24-bit top colour over a 24-bit bottom colour with one alpha.
module rgb_blend
    import compositor_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [7:0]       alpha,
    input  logic [NCH*8-1:0] top,
    input  logic [NCH*8-1:0] bot,
    output logic [NCH*8-1:0] mixed
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Per-channel rounded mix.
        always_comb mixed[c*8 +: 8] = mix8(alpha, top[c*8 +: 8], bot[c*8 +: 8]);
    end
endmodule

// File: rtl/layer_compositor.sv
// Two-stage compositor: per-pipe priority selection, then pipe 0 over the
// background and pipe 1 over that. Two-edge latency, output held between
// valid pixels. Assumes layer pixels are already decoded to ARGB8888.
module layer_compositor
    import compositor_pkg::*;
#(
    parameter int NL = 4,
    parameter int CW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             px_valid,
    input  logic [CW-1:0]    px_x,
    input  logic [CW-1:0]    px_y,
    input  logic [CW-1:0]    disp_w,
    input  logic [CW-1:0]    disp_h,
    input  logic [23:0]      bg_rgb,
    input  logic             quirk_en,
    input  logic [NL-1:0]    lay_en,
    input  logic [NL*CW-1:0] lay_x,
    input  logic [NL*CW-1:0] lay_y,
    input  logic [NL*CW-1:0] lay_w,
    input  logic [NL*CW-1:0] lay_h,
    input  logic [NL-1:0]    lay_pipe,
    input  logic [NL*2-1:0]  lay_prio,
    input  logic [NL*8-1:0]  lay_galpha,
    input  logic [NL-1:0]    lay_galpha_en,
    input  logic [NL*32-1:0] lay_argb,
    output logic             out_valid,
    output logic [23:0]      out_rgb
);
    localparam int PW     = 2;
    localparam int NPIPES = 2;

    logic              in_disp;
    logic [NL-1:0]     hit_raw, hit;
    logic [NL*32-1:0]  eff_flat;
    logic [NPIPES-1:0] found;
    logic [31:0]       pipe_pix [NPIPES];
    logic [PW-1:0]     pipe_prio[NPIPES];
    logic [7:0]        a0, a1;
    logic [23:0]       c0, final_rgb;
    logic              s1_valid;
    logic [23:0]       s1_c0, s1_top;
    logic [7:0]        s1_a1;

    // Coordinates off the active display see no layer at all.
    always_comb begin
        in_disp = (px_x < disp_w) && (px_y < disp_h);
        hit     = hit_raw & {NL{in_disp}};
    end

    for (genvar g = 0; g < NL; g++) begin : g_lay
        argb_t eff;
        layer_cover #(.CW(CW)) u_cover (
            .en        (lay_en[g]),
            .px_x      (px_x),
            .px_y      (px_y),
            .lx        (lay_x[g*CW +: CW]),
            .ly        (lay_y[g*CW +: CW]),
            .lw        (lay_w[g*CW +: CW]),
            .lh        (lay_h[g*CW +: CW]),
            .argb_in   (lay_argb[g*32 +: 32]),
            .galpha    (lay_galpha[g*8 +: 8]),
            .galpha_en (lay_galpha_en[g]),
            .hit       (hit_raw[g]),
            .eff       (eff)
        );
        assign eff_flat[g*32 +: 32] = eff;
    end

    for (genvar p = 0; p < NPIPES; p++) begin : g_pipe
        pipe_select #(.NL(NL), .PW(PW), .PIPE_ID(p[0])) u_sel (
            .hit      (hit),
            .pipe_sel (lay_pipe),
            .prio     (lay_prio),
            .px       (eff_flat),
            .found    (found[p]),
            .pix      (pipe_pix[p]),
            .win_prio (pipe_prio[p])
        );
    end

    // Pipe alphas: empty pipe is transparent; defect mode drops a
    // translucent lowest-slot pixel from pipe 0.
    always_comb begin
        a0 = found[0] ? pipe_pix[0][31:24] : 8'd0;
        if (quirk_en && found[0] && (pipe_prio[0] == '0) && (pipe_pix[0][31:24] != 8'hFF))
            a0 = 8'd0;
        a1 = found[1] ? pipe_pix[1][31:24] : 8'd0;
    end

    rgb_blend u_blend0 (.alpha(a0), .top(pipe_pix[0][23:0]), .bot(bg_rgb), .mixed(c0));

    // Stage 1 register: pipe 0 over background, pipe 1 operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_c0    <= '0;
            s1_top   <= '0;
            s1_a1    <= '0;
        end else begin
            s1_valid <= px_valid;
            if (px_valid) begin
                s1_c0  <= c0;
                s1_top <= pipe_pix[1][23:0];
                s1_a1  <= a1;
            end
        end
    end

    rgb_blend u_blend1 (.alpha(s1_a1), .top(s1_top), .bot(s1_c0), .mixed(final_rgb));

    // Stage 2 register: final colour, held while no pixel arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_rgb <= final_rgb;
        end
    end
endmodule

// File: rtl/compositor_checker.sv
// Cycle-by-cycle properties of the compositor, bound to every instance.
module compositor_checker #(
    parameter int NL = 4,
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          px_valid,
    input logic [CW-1:0] px_x,
    input logic [CW-1:0] px_y,
    input logic [CW-1:0] disp_w,
    input logic [CW-1:0] disp_h,
    input logic [NL-1:0] lay_en,
    input logic [23:0]   bg_rgb,
    input logic          out_valid,
    input logic [23:0]   out_rgb
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> ##2 out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid |-> ##2 !out_valid); // R1
    AST_EMPTY_SHOWS_BG: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && lay_en == '0) |-> ##2 (out_rgb == $past(bg_rgb, 2))); // R2
    AST_OFFSCREEN_BG: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && (px_x >= disp_w || px_y >= disp_h)) |-> ##2 (out_rgb == $past(bg_rgb, 2))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_rgb)); // R10
endmodule

bind layer_compositor compositor_checker #(.NL(NL), .CW(CW)) u_chk (.*);

// File: tb/layer_compositor_tb.sv
// Directed scenarios for the two-pipe compositor.
module layer_compositor_tb;
    localparam int NL = 4;
    localparam int CW = 11;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             px_valid;
    logic [CW-1:0]    px_x, px_y, disp_w, disp_h;
    logic [23:0]      bg_rgb;
    logic             quirk_en;
    logic [NL-1:0]    lay_en, lay_pipe, lay_galpha_en;
    logic [NL*CW-1:0] lay_x, lay_y, lay_w, lay_h;
    logic [NL*2-1:0]  lay_prio;
    logic [NL*8-1:0]  lay_galpha;
    logic [NL*32-1:0] lay_argb;
    logic             out_valid;
    logic [23:0]      out_rgb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    layer_compositor #(.NL(NL), .CW(CW)) u_dut (.*);

    function automatic logic [7:0] bl(input int a, input int t, input int b);
        return 8'((a * t + (255 - a) * b + 127) / 255);
    endfunction

    function automatic logic [23:0] blrgb(input int a, input logic [23:0] t, input logic [23:0] b);
        return {bl(a, t[23:16], b[23:16]), bl(a, t[15:8], b[15:8]), bl(a, t[7:0], b[7:0])};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_layer(input int i, input bit en, input int x, input int y, input int w,
                             input int h, input bit pipe, input int prio, input int ga,
                             input bit ga_en, input logic [31:0] argb);
        lay_en[i]             = en;
        lay_x[i*CW +: CW]     = CW'(x);
        lay_y[i*CW +: CW]     = CW'(y);
        lay_w[i*CW +: CW]     = CW'(w);
        lay_h[i*CW +: CW]     = CW'(h);
        lay_pipe[i]           = pipe;
        lay_prio[i*2 +: 2]    = 2'(prio);
        lay_galpha[i*8 +: 8]  = 8'(ga);
        lay_galpha_en[i]      = ga_en;
        lay_argb[i*32 +: 32]  = argb;
    endtask

    task automatic clear_layers();
        for (int i = 0; i < NL; i++) set_layer(i, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
        quirk_en = 1'b0;
    endtask

    // Drive one coordinate and check the pixel two edges later (R1 timing).
    task automatic probe(input int x, input int y, input logic [23:0] exp, input string tag);
        @(negedge clk);
        px_valid = 1'b1;
        px_x = CW'(x);
        px_y = CW'(y);
        @(negedge clk);
        px_valid = 1'b0;
        @(negedge clk);
        check({tag, " R1 valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, {8'd0, out_rgb}, {8'd0, exp});
        @(negedge clk);
        check("R1 valid drops", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset rgb", {8'd0, out_rgb}, 32'd0);
    endtask

    task automatic t_empty();
        clear_layers();
        bg_rgb = 24'h102030;
        probe(5, 5, 24'h102030, "R2 no layer");
        set_layer(0, 0, 0, 0, 100, 100, 0, 3, 0, 0, 32'hFF_AABBCC);
        probe(5, 5, 24'h102030, "R2 disabled layer");
    endtask

    task automatic t_coverage();
        clear_layers();
        set_layer(0, 1, 10, 20, 30, 40, 0, 0, 0, 0, 32'hFF_112233);
        probe(10, 20, 24'h112233, "R2 top-left corner");
        probe(39, 59, 24'h112233, "R2 bottom-right inside");
        probe(40, 30, 24'h102030, "R2 right edge excluded");
        probe(20, 60, 24'h102030, "R2 bottom edge excluded");
        probe(9, 30, 24'h102030, "R2 left of layer");
    endtask

    task automatic t_offscreen();
        clear_layers();
        set_layer(0, 1, 0, 0, 2000, 2000, 0, 0, 0, 0, 32'hFF_445566);
        probe(639, 479, 24'h445566, "R3 last visible");
        probe(640, 10, 24'h102030, "R3 beyond width");
        probe(10, 480, 24'h102030, "R3 beyond height");
    endtask

    task automatic t_priority();
        clear_layers();
        set_layer(0, 1, 0, 0, 50, 50, 0, 1, 0, 0, 32'hFF_010101);
        set_layer(1, 1, 0, 0, 50, 50, 0, 3, 0, 0, 32'hFF_C0C0C0);
        probe(3, 3, 24'hC0C0C0, "R4 higher priority wins");
        set_layer(1, 1, 0, 0, 50, 50, 0, 3, 0, 0, 32'h80_C0C0C0);
        probe(3, 3, blrgb(128, 24'hC0C0C0, 24'h102030), "R4 no intra-pipe blend");
        set_layer(1, 1, 0, 0, 50, 50, 0, 1, 0, 0, 32'hFF_C0C0C0);
        probe(3, 3, 24'h010101, "R4 tie lower index");
        set_layer(1, 1, 0, 0, 50, 50, 1, 0, 0, 0, 32'hFF_C0C0C0);
        probe(3, 3, 24'hC0C0C0, "R6 pipe1 opaque over pipe0");
    endtask

    task automatic t_galpha();
        clear_layers();
        set_layer(0, 1, 0, 0, 50, 50, 0, 0, 0, 0, 32'hFF_204060);
        set_layer(2, 1, 0, 0, 50, 50, 1, 0, 128, 1, 32'hFF_E0A080);
        probe(1, 1, blrgb(128, 24'hE0A080, 24'h204060), "R5 global alpha scales");
        set_layer(2, 1, 0, 0, 50, 50, 1, 0, 128, 0, 32'hFF_E0A080);
        probe(1, 1, 24'hE0A080, "R5 global alpha disabled");
        set_layer(2, 1, 0, 0, 50, 50, 1, 0, 128, 1, 32'h80_E0A080);
        probe(1, 1, blrgb(64, 24'hE0A080, 24'h204060), "R5 product rounding");
    endtask

    task automatic t_two_stage();
        clear_layers();
        set_layer(0, 1, 0, 0, 50, 50, 0, 2, 0, 0, 32'h40_F08010);
        probe(2, 2, blrgb(64, 24'hF08010, 24'h102030), "R7 empty pipe1 transparent");
        set_layer(3, 1, 0, 0, 50, 50, 1, 0, 0, 0, 32'h99_0A0B0C);
        probe(2, 2, blrgb(153, 24'h0A0B0C, blrgb(64, 24'hF08010, 24'h102030)),
              "R6 both stages");
        set_layer(0, 0, 0, 0, 50, 50, 0, 2, 0, 0, 32'h40_F08010);
        probe(2, 2, blrgb(153, 24'h0A0B0C, 24'h102030), "R7 empty pipe0 transparent");
    endtask

    task automatic t_quirk();
        clear_layers();
        set_layer(0, 1, 0, 0, 50, 50, 0, 0, 0, 0, 32'h80_FFFFFF);
        probe(4, 4, blrgb(128, 24'hFFFFFF, 24'h102030), "R8 quirk off blends");
        quirk_en = 1'b1;
        probe(4, 4, 24'h102030, "R8 quirk drops lowest slot");
        set_layer(1, 1, 0, 0, 50, 50, 1, 0, 0, 0, 32'h80_00FF00);
        probe(4, 4, blrgb(128, 24'h00FF00, 24'h102030), "R8 pipe1 over background");
        set_layer(0, 1, 0, 0, 50, 50, 0, 1, 0, 0, 32'h80_FFFFFF);
        set_layer(1, 0, 0, 0, 50, 50, 1, 0, 0, 0, 32'h80_00FF00);
        probe(4, 4, blrgb(128, 24'hFFFFFF, 24'h102030), "R8 priority 1 unaffected");
        set_layer(0, 1, 0, 0, 50, 50, 0, 0, 0, 0, 32'hFF_FFFFFF);
        probe(4, 4, 24'hFFFFFF, "R8 opaque lowest slot kept");
        set_layer(0, 1, 0, 0, 50, 50, 0, 0, 200, 1, 32'hFF_FFFFFF);
        probe(4, 4, 24'h102030, "R8 global alpha makes it translucent");
    endtask

    task automatic t_hold();
        clear_layers();
        set_layer(0, 1, 0, 0, 50, 50, 0, 0, 0, 0, 32'hFF_5A5A5A);
        probe(1, 1, 24'h5A5A5A, "R10 setup pixel");
        set_layer(0, 1, 0, 0, 50, 50, 0, 0, 0, 0, 32'hFF_A5A5A5);
        bg_rgb = 24'h777777;
        repeat (5) @(negedge clk);
        check("R10 held while idle", {8'd0, out_rgb}, 32'h005A5A5A);
        check("R10 valid low while idle", {31'd0, out_valid}, 32'd0);
        bg_rgb = 24'h102030;
    endtask

    initial begin
        rst_n = 1'b0; px_valid = 1'b0; px_x = '0; px_y = '0;
        disp_w = CW'(640); disp_h = CW'(480);
        bg_rgb = 24'h102030;
        lay_en = '0; lay_pipe = '0; lay_galpha_en = '0;
        lay_x = '0; lay_y = '0; lay_w = '0; lay_h = '0;
        lay_prio = '0; lay_galpha = '0; lay_argb = '0; quirk_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_coverage();
        t_offscreen();
        t_priority();
        t_galpha();
        t_two_stage();
        t_quirk();
        t_hold();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule